// File: doc/BRIEF.md
# Oldest-First Out-of-Order Issue Queue

This block is the scheduling window between rename and the integer execution pipes. It holds up to 20 renamed instructions. Each entry waits until both of its physical source operands are marked available. Every cycle the queue offers up to four waiting instructions to the execution side. When more instructions are eligible than there are slots, the oldest ones go first. Age comes from a wrapping sequence number that the front end assigns in program order.

Instructions arrive in groups of up to two lanes on a valid/ready stream. The sender must hold a group, unchanged, until `disp_ready` is seen high on the same edge as `disp_valid`. A group presented while `disp_ready` is low is not taken. Completing producers broadcast their destination tags on two wakeup ports, and waiting sources whose tags match become available. Selection is speculative. The control logic can therefore issue a squash with a sequence number, which discards every held instruction that is younger than that point. An offered instruction is taken by the execution side without a handshake, and its entry is freed at that edge.

Top module: `oldest_issue_queue`

## Requirements
- R1: After reset the queue is empty: no issue slot is valid and `disp_ready` is high.
- R2: `disp_ready` is high exactly when at least 2 entries are free, so a queue with only one free entry back-pressures. A group is taken only on a cycle with `disp_valid` and `disp_ready` both high, and a group offered while `disp_ready` is low leaves no entry. A lane whose `disp_lane_en` bit is 0 creates no entry.
- R3: An entry is offered only when both of its source ready bits are set. A newly accepted instruction can be offered no earlier than the cycle after the one in which it was accepted.
- R4: At most 4 entries are offered per cycle, and the valid slots are packed from slot 0 upward.
- R5: Slot 0 holds the oldest offered entry, and later slots hold successively younger ones. No eligible entry that is left unoffered is older than an offered one.
- R6: A `wake_en[w]` pulse carrying `wake_tag[w]` sets every resident source ready bit whose tag matches. The entry becomes eligible in the following cycle. Both wakeup ports act in the same cycle.
- R7: A lane accepted in the same cycle that its source tag is broadcast on a wakeup port is stored with that source already ready.
- R8: An offered entry is freed at the clock edge that ends the cycle in which it is offered, and it is never offered again.
- R9: `squash_en` with `squash_seq` removes every entry strictly younger than `squash_seq` and keeps equal and older entries. Removed entries are not offered in the squash cycle. Lanes accepted in that cycle that are younger than the squash point are discarded.
- R10: Sequence number a is older than b when (a - b) mod 256 lies in 128..255, so ages order correctly across the wrap from 255 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 1 | Dispatch group present |
| disp_ready | output | 1 | Queue can take a full group |
| disp_lane_en | input | 2 | Per-lane enable inside the group |
| disp_src1 | input | 2x7 | First source tag per lane |
| disp_rdy1 | input | 2 | First source already available, per lane |
| disp_src2 | input | 2x7 | Second source tag per lane |
| disp_rdy2 | input | 2 | Second source already available, per lane |
| disp_dst | input | 2x7 | Destination tag per lane |
| disp_seq | input | 2x8 | Age sequence number per lane |
| wake_en | input | 2 | Wakeup broadcast valid per port |
| wake_tag | input | 2x7 | Broadcast destination tag per port |
| squash_en | input | 1 | Discard entries younger than `squash_seq` |
| squash_seq | input | 8 | Squash point |
| iss_valid | output | 4 | Issue slot valid |
| iss_src1 | output | 4x7 | First source tag per slot |
| iss_src2 | output | 4x7 | Second source tag per slot |
| iss_dst | output | 4x7 | Destination tag per slot |
| iss_seq | output | 4x8 | Sequence number per slot |

## Verification
Two pairs of functions can meet in one cycle.

The first pair is wakeup and dispatch. The bench accepts a consumer on the same edge that its producer's tag is broadcast. It expects the consumer in slot 0 on the next cycle. As a control, a broadcast of a non-matching tag must leave the consumer idle until its own tag arrives.

The second pair is squash and selection. Two ready entries are presented to the issue side, and the squash is raised in that same cycle at the older one's number. Only the older entry may appear. Separately, a squash raised together with a dispatch group must drop the younger lane and keep the older one, which the bench judges later by the exact drain order.

// File: rtl/iq_pkg.sv
package iq_pkg;
  parameter int unsigned TAG_W = 7;
  parameter int unsigned SEQ_W = 8;

  typedef logic [TAG_W-1:0] tag_t;
  typedef logic [SEQ_W-1:0] seq_t;

  // One renamed instruction as held by a queue entry.
  typedef struct packed {
    tag_t src1;
    logic rdy1;
    tag_t src2;
    logic rdy2;
    tag_t dst;
    seq_t seq;
  } uop_t;

  // True when sequence number a precedes b in program order (modular distance).
  function automatic logic seq_older(seq_t a, seq_t b);
    seq_t diff;
    diff = a - b;
    return diff[SEQ_W-1];
  endfunction
endpackage

// File: rtl/iq_slot.sv
module iq_slot
  import iq_pkg::*;
#(
  parameter int unsigned WAKE_W = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          alloc_we,
  input  uop_t                          alloc_uop,
  input  logic [WAKE_W-1:0]             wake_en,
  input  logic [WAKE_W-1:0][TAG_W-1:0]  wake_tag,
  input  logic                          issue_clr,
  input  logic                          squash_en,
  input  logic [SEQ_W-1:0]              squash_seq,
  output logic                          vld,
  output logic                          eligible,
  output logic [TAG_W-1:0]              ent_src1,
  output logic [TAG_W-1:0]              ent_src2,
  output logic [TAG_W-1:0]              ent_dst,
  output logic [SEQ_W-1:0]              ent_seq
);
  uop_t held;
  logic hit1, hit2, new_hit1, new_hit2;
  logic kill, new_kill;

  // Tag match against every broadcast port, for held and incoming sources.
  always_comb begin
    hit1 = 1'b0;
    hit2 = 1'b0;
    new_hit1 = 1'b0;
    new_hit2 = 1'b0;
    for (int w = 0; w < WAKE_W; w++) begin
      if (wake_en[w]) begin
        if (wake_tag[w] == held.src1)      hit1 = 1'b1;
        if (wake_tag[w] == held.src2)      hit2 = 1'b1;
        if (wake_tag[w] == alloc_uop.src1) new_hit1 = 1'b1;
        if (wake_tag[w] == alloc_uop.src2) new_hit2 = 1'b1;
      end
    end
  end

  always_comb begin
    kill     = vld && squash_en && seq_older(squash_seq, held.seq);
    new_kill = squash_en && seq_older(squash_seq, alloc_uop.seq);
    eligible = vld && held.rdy1 && held.rdy2 && !kill;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld  <= 1'b0;
      held <= '0;
    end else if (alloc_we) begin
      vld       <= !new_kill;
      held      <= alloc_uop;
      held.rdy1 <= alloc_uop.rdy1 | new_hit1;
      held.rdy2 <= alloc_uop.rdy2 | new_hit2;
    end else if (vld) begin
      if (issue_clr || kill) vld <= 1'b0;
      if (hit1) held.rdy1 <= 1'b1;
      if (hit2) held.rdy2 <= 1'b1;
    end
  end

  assign ent_src1 = held.src1;
  assign ent_src2 = held.src2;
  assign ent_dst  = held.dst;
  assign ent_seq  = held.seq;
endmodule

// File: rtl/iq_alloc.sv
module iq_alloc #(
  parameter int unsigned DEPTH  = 20,
  parameter int unsigned DISP_W = 2,
  parameter int unsigned LANE_W = 1,
  parameter int unsigned CNT_W  = 5
) (
  input  logic [DEPTH-1:0]             free_mask,
  input  logic [DISP_W-1:0]            lane_en,
  input  logic                         fire,
  output logic [DEPTH-1:0]             we,
  output logic [DEPTH-1:0][LANE_W-1:0] lane_sel,
  output logic [CNT_W-1:0]             free_cnt
);
  logic [DEPTH-1:0][CNT_W-1:0] pos;

  // Running count of free entries below each index: lane l lands on the l-th free entry.
  always_comb begin
    logic [CNT_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < DEPTH; i++) begin
      pos[i] = acc;
      if (free_mask[i]) acc = acc + CNT_W'(1);
    end
    free_cnt = acc;
  end

  always_comb begin
    we       = '0;
    lane_sel = '0;
    for (int i = 0; i < DEPTH; i++) begin
      for (int l = 0; l < DISP_W; l++) begin
        if (fire && free_mask[i] && lane_en[l] && pos[i] == CNT_W'(l)) begin
          we[i]       = 1'b1;
          lane_sel[i] = LANE_W'(l);
        end
      end
    end
  end
endmodule

// File: rtl/iq_select.sv
module iq_select
  import iq_pkg::*;
#(
  parameter int unsigned DEPTH   = 20,
  parameter int unsigned ISSUE_W = 4,
  parameter int unsigned IDX_W   = 5,
  parameter int unsigned CNT_W   = 5
) (
  input  logic [DEPTH-1:0]              elig,
  input  logic [DEPTH-1:0][SEQ_W-1:0]   seqs,
  output logic [DEPTH-1:0]              grant,
  output logic [ISSUE_W-1:0]            slot_vld,
  output logic [ISSUE_W-1:0][IDX_W-1:0] slot_idx
);
  logic [DEPTH-1:0][CNT_W-1:0] rank;

  // Rank of each entry = number of eligible entries older than it.
  for (genvar i = 0; i < DEPTH; i++) begin : g_rank
    logic [CNT_W-1:0] r;
    always_comb begin
      r = '0;
      for (int j = 0; j < DEPTH; j++) begin
        if (j != i && elig[j] && seq_older(seqs[j], seqs[i])) r = r + CNT_W'(1);
      end
    end
    assign rank[i]  = r;
    assign grant[i] = elig[i] && (r < CNT_W'(ISSUE_W));
  end

  // Slot k carries the granted entry of rank k.
  always_comb begin
    slot_vld = '0;
    slot_idx = '0;
    for (int k = 0; k < ISSUE_W; k++) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (grant[i] && rank[i] == CNT_W'(k)) begin
          slot_vld[k] = 1'b1;
          slot_idx[k] = IDX_W'(i);
        end
      end
    end
  end
endmodule

// File: rtl/oldest_issue_queue.sv
module oldest_issue_queue
  import iq_pkg::*;
#(
  parameter int unsigned DEPTH   = 20,
  parameter int unsigned ISSUE_W = 4,
  parameter int unsigned DISP_W  = 2,
  parameter int unsigned WAKE_W  = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           disp_valid,
  output logic                           disp_ready,
  input  logic [DISP_W-1:0]              disp_lane_en,
  input  logic [DISP_W-1:0][TAG_W-1:0]   disp_src1,
  input  logic [DISP_W-1:0]              disp_rdy1,
  input  logic [DISP_W-1:0][TAG_W-1:0]   disp_src2,
  input  logic [DISP_W-1:0]              disp_rdy2,
  input  logic [DISP_W-1:0][TAG_W-1:0]   disp_dst,
  input  logic [DISP_W-1:0][SEQ_W-1:0]   disp_seq,
  input  logic [WAKE_W-1:0]              wake_en,
  input  logic [WAKE_W-1:0][TAG_W-1:0]   wake_tag,
  input  logic                           squash_en,
  input  logic [SEQ_W-1:0]               squash_seq,
  output logic [ISSUE_W-1:0]             iss_valid,
  output logic [ISSUE_W-1:0][TAG_W-1:0]  iss_src1,
  output logic [ISSUE_W-1:0][TAG_W-1:0]  iss_src2,
  output logic [ISSUE_W-1:0][TAG_W-1:0]  iss_dst,
  output logic [ISSUE_W-1:0][SEQ_W-1:0]  iss_seq
);
  localparam int unsigned IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1);
  localparam int unsigned LANE_W = (DISP_W > 1) ? $clog2(DISP_W) : 1;

  logic [DEPTH-1:0]              vld;
  logic [DEPTH-1:0]              elig;
  logic [DEPTH-1:0]              we;
  logic [DEPTH-1:0]              grant;
  logic [DEPTH-1:0][LANE_W-1:0]  lane_sel;
  logic [DEPTH-1:0][TAG_W-1:0]   e_src1, e_src2, e_dst;
  logic [DEPTH-1:0][SEQ_W-1:0]   e_seq;
  logic [CNT_W-1:0]              free_cnt;
  logic [ISSUE_W-1:0]            slot_vld;
  logic [ISSUE_W-1:0][IDX_W-1:0] slot_idx;
  logic                          fire;
  uop_t                          lane_uop [DISP_W];

  // Whole-group back-pressure on the occupancy seen at the start of the cycle.
  assign disp_ready = (free_cnt >= CNT_W'(DISP_W));
  assign fire       = disp_valid && disp_ready;

  for (genvar l = 0; l < DISP_W; l++) begin : g_lane
    assign lane_uop[l] = '{src1: disp_src1[l], rdy1: disp_rdy1[l],
                           src2: disp_src2[l], rdy2: disp_rdy2[l],
                           dst:  disp_dst[l],  seq:  disp_seq[l]};
  end

  iq_alloc #(
    .DEPTH(DEPTH), .DISP_W(DISP_W), .LANE_W(LANE_W), .CNT_W(CNT_W)
  ) u_alloc (
    .free_mask(~vld),
    .lane_en  (disp_lane_en),
    .fire     (fire),
    .we       (we),
    .lane_sel (lane_sel),
    .free_cnt (free_cnt)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    iq_slot #(.WAKE_W(WAKE_W)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .alloc_we  (we[i]),
      .alloc_uop (lane_uop[lane_sel[i]]),
      .wake_en   (wake_en),
      .wake_tag  (wake_tag),
      .issue_clr (grant[i]),
      .squash_en (squash_en),
      .squash_seq(squash_seq),
      .vld       (vld[i]),
      .eligible  (elig[i]),
      .ent_src1  (e_src1[i]),
      .ent_src2  (e_src2[i]),
      .ent_dst   (e_dst[i]),
      .ent_seq   (e_seq[i])
    );
  end

  iq_select #(
    .DEPTH(DEPTH), .ISSUE_W(ISSUE_W), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) u_select (
    .elig    (elig),
    .seqs    (e_seq),
    .grant   (grant),
    .slot_vld(slot_vld),
    .slot_idx(slot_idx)
  );

  always_comb begin
    for (int k = 0; k < ISSUE_W; k++) begin
      iss_valid[k] = slot_vld[k];
      iss_src1[k]  = e_src1[slot_idx[k]];
      iss_src2[k]  = e_src2[slot_idx[k]];
      iss_dst[k]   = e_dst[slot_idx[k]];
      iss_seq[k]   = e_seq[slot_idx[k]];
    end
  end
endmodule

// File: rtl/iq_checker.sv
module iq_checker
  import iq_pkg::*;
#(
  parameter int unsigned ISSUE_W = 4
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [ISSUE_W-1:0]            iss_valid,
  input logic [ISSUE_W-1:0][SEQ_W-1:0] iss_seq,
  input logic                          squash_en,
  input logic [SEQ_W-1:0]              squash_seq
);
  for (genvar k = 1; k < ISSUE_W; k++) begin : g_pair
    AST_SLOT_PACKED: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid[k] |-> iss_valid[k-1]); // R4
    AST_SLOT_AGE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid[k] |-> seq_older(iss_seq[k-1], iss_seq[k])); // R5
  end

  for (genvar k = 0; k < ISSUE_W; k++) begin : g_slot
    AST_SQUASHED_NOT_OFFERED: assert property (@(posedge clk) disable iff (!rst_n)
      (squash_en && iss_valid[k]) |-> !seq_older(squash_seq, iss_seq[k])); // R9
    for (genvar m = 0; m < ISSUE_W; m++) begin : g_other
      AST_NO_REOFFER: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid[k] |=> !(iss_valid[m] && iss_seq[m] == $past(iss_seq[k]))); // R8
    end
  end
endmodule

bind oldest_issue_queue iq_checker #(.ISSUE_W(ISSUE_W)) u_iq_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .iss_valid (iss_valid),
  .iss_seq   (iss_seq),
  .squash_en (squash_en),
  .squash_seq(squash_seq)
);

// File: tb/tb_oldest_issue_queue.sv
module tb_oldest_issue_queue;
  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             disp_valid;
  logic             disp_ready;
  logic [1:0]       disp_lane_en;
  logic [1:0][6:0]  disp_src1, disp_src2, disp_dst;
  logic [1:0]       disp_rdy1, disp_rdy2;
  logic [1:0][7:0]  disp_seq;
  logic [1:0]       wake_en;
  logic [1:0][6:0]  wake_tag;
  logic             squash_en;
  logic [7:0]       squash_seq;
  logic [3:0]       iss_valid;
  logic [3:0][6:0]  iss_src1, iss_src2, iss_dst;
  logic [3:0][7:0]  iss_seq;

  int n_chk = 0;
  int n_fail = 0;
  int el[19];

  always #4 clk = ~clk;

  oldest_issue_queue dut (
    .clk(clk), .rst_n(rst_n),
    .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_lane_en(disp_lane_en),
    .disp_src1(disp_src1), .disp_rdy1(disp_rdy1), .disp_src2(disp_src2),
    .disp_rdy2(disp_rdy2), .disp_dst(disp_dst), .disp_seq(disp_seq),
    .wake_en(wake_en), .wake_tag(wake_tag),
    .squash_en(squash_en), .squash_seq(squash_seq),
    .iss_valid(iss_valid), .iss_src1(iss_src1), .iss_src2(iss_src2),
    .iss_dst(iss_dst), .iss_seq(iss_seq)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // Compare the four issue slots against n expected sequence numbers.
  task automatic chk_iss(string req, int n, int e0, int e1, int e2, int e3);
    int e[4];
    e = '{e0, e1, e2, e3};
    #1;
    for (int k = 0; k < 4; k++) begin
      chk({req, " slot valid"}, int'(iss_valid[k]), (k < n) ? 1 : 0);
      if (k < n) chk({req, " slot seq"}, int'(iss_seq[k]), e[k]);
    end
  endtask

  task automatic idle();
    disp_valid = 1'b0; disp_lane_en = '0;
    disp_src1 = '0; disp_src2 = '0; disp_dst = '0;
    disp_rdy1 = '0; disp_rdy2 = '0; disp_seq = '0;
    wake_en = '0; wake_tag = '0;
    squash_en = 1'b0; squash_seq = '0;
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic put(int lane, int s1, int r1, int s2, int r2, int seq);
    disp_valid = 1'b1;
    disp_lane_en[lane] = 1'b1;
    disp_src1[lane] = 7'(s1);
    disp_rdy1[lane] = 1'(r1);
    disp_src2[lane] = 7'(s2);
    disp_rdy2[lane] = 1'(r2);
    disp_dst[lane]  = 7'(seq);
    disp_seq[lane]  = 8'(seq);
  endtask

  task automatic wake(int port, int tag);
    wake_en[port]  = 1'b1;
    wake_tag[port] = 7'(tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    #1;
    chk("R1 ready in reset", int'(disp_ready), 1);
    chk("R1 idle in reset", int'(iss_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 ready after reset", int'(disp_ready), 1);
    chk("R1 idle after reset", int'(iss_valid), 0);

    // R2 fill sweep: 19 single-lane entries, ages scrambled by a stride of 7.
    for (int n = 0; n < 19; n++) begin
      #1 chk("R2 ready while >=2 free", int'(disp_ready), 1);
      put(0, 1, 1, 5, 0, 40 + (7 * n) % 20);
      cyc();
    end
    #1 chk("R2 ready low with 1 free", int'(disp_ready), 0);
    put(0, 1, 1, 5, 0, 30);            // refused group, would be oldest if taken
    cyc();
    #1 chk("R2 still low", int'(disp_ready), 0);
    wake(0, 5);
    chk_iss("R6 no issue in wake cycle", 0, 0, 0, 0, 0);
    cyc();
    begin
      int w;
      w = 0;
      for (int v = 40; v < 60; v++) if (v != 53) begin el[w] = v; w++; end
    end
    for (int c = 0; c < 5; c++) begin
      int b;
      b = c * 4;
      chk_iss("R5 R4 drain oldest first", (c < 4) ? 4 : 3,
              el[b], el[b + 1], el[b + 2], (b + 3 < 19) ? el[b + 3] : 0);
      cyc();
    end
    chk_iss("R8 drained queue idle", 0, 0, 0, 0, 0);
    chk("R8 ready after drain", int'(disp_ready), 1);

    // R3: readiness combinations; only the fully ready one goes.
    put(0, 40, 0, 41, 0, 60); put(1, 42, 0, 1, 1, 61);
    chk_iss("R3 empty queue", 0, 0, 0, 0, 0);
    cyc();
    put(0, 1, 1, 43, 0, 62); put(1, 1, 1, 1, 1, 63);
    chk_iss("R3 none ready", 0, 0, 0, 0, 0);
    cyc();
    wake(0, 40); wake(1, 41);
    chk_iss("R3 only both-ready offered", 1, 63, 0, 0, 0);
    cyc();
    wake(0, 42); wake(1, 43);
    chk_iss("R6 two ports same cycle", 1, 60, 0, 0, 0);
    cyc();
    chk_iss("R6 partial wakes completed", 2, 61, 62, 0, 0);
    cyc();
    chk_iss("R8 empty again", 0, 0, 0, 0, 0);

    // R7: dispatch meets matching wakeup; lane 1 disabled with ready payload.
    put(0, 9, 0, 1, 1, 70);
    disp_src1[1] = 7'd1; disp_rdy1[1] = 1'b1; disp_src2[1] = 7'd1;
    disp_rdy2[1] = 1'b1; disp_seq[1] = 8'd72;
    wake(0, 9);
    cyc();
    chk_iss("R7 R2 same-cycle wake, disabled lane absent", 1, 70, 0, 0, 0);
    put(0, 11, 0, 1, 1, 71);
    wake(0, 12);
    cyc();
    chk_iss("R6 non-matching tag", 0, 0, 0, 0, 0);
    wake(1, 11);
    cyc();
    chk_iss("R6 matching tag", 1, 71, 0, 0, 0);
    cyc();

    // R10: ages straddling the wrap.
    put(0, 1, 1, 6, 0, 2);   put(1, 1, 1, 6, 0, 254); cyc();
    put(0, 1, 1, 6, 0, 0);   put(1, 1, 1, 6, 0, 252); cyc();
    put(0, 1, 1, 6, 0, 5);   put(1, 1, 1, 6, 0, 255); cyc();
    put(0, 1, 1, 6, 0, 1);   put(1, 1, 1, 6, 0, 253); cyc();
    wake(0, 6);
    cyc();
    chk_iss("R10 wrap first four", 4, 252, 253, 254, 255);
    cyc();
    chk_iss("R10 wrap next four", 4, 0, 1, 2, 5);
    cyc();
    chk_iss("R10 drained", 0, 0, 0, 0, 0);

    // R9: squash with a concurrent dispatch group.
    for (int s = 10; s < 18; s += 2) begin
      put(0, 1, 1, 7, 0, s); put(1, 1, 1, 7, 0, s + 1); cyc();
    end
    put(0, 1, 1, 7, 0, 9); put(1, 1, 1, 7, 0, 20);
    squash_en = 1'b1; squash_seq = 8'd13;
    cyc();
    wake(0, 7);
    chk_iss("R9 nothing ready", 0, 0, 0, 0, 0);
    cyc();
    chk_iss("R9 survivors oldest first", 4, 9, 10, 11, 12);
    cyc();
    chk_iss("R9 squash point kept", 1, 13, 0, 0, 0);
    cyc();
    chk_iss("R9 younger removed", 0, 0, 0, 0, 0);

    // R9 with wrap: 251 and 2 are younger than 250, 249 is older.
    put(0, 1, 1, 7, 0, 249); put(1, 1, 1, 7, 0, 251); cyc();
    put(0, 1, 1, 7, 0, 2); cyc();
    squash_en = 1'b1; squash_seq = 8'd250;
    cyc();
    wake(0, 7);
    cyc();
    chk_iss("R9 R10 wrapped squash", 1, 249, 0, 0, 0);
    cyc();
    chk_iss("R9 wrapped drained", 0, 0, 0, 0, 0);

    // R9: squash in the same cycle as selection masks the younger entry.
    put(0, 1, 1, 1, 1, 30); put(1, 1, 1, 1, 1, 31);
    cyc();
    squash_en = 1'b1; squash_seq = 8'd30;
    chk_iss("R9 same-cycle squash and select", 1, 30, 0, 0, 0);
    cyc();
    chk_iss("R9 masked entry gone", 0, 0, 0, 0, 0);
    chk("R2 ready at end", int'(disp_ready), 1);

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule